// File: doc/BRIEF.md
# Fast-Page DRAM Access Controller with Timed Refresh

This block connects a simple byte-wide host to an 8M x 8 asynchronous DRAM that supports fast page cycles. A host request carries a 23-bit byte address, a write flag and write data. The controller splits the address into a row part and a column part and puts each one on a shared, multiplexed address bus. It drives the active-low row strobe, column strobe, write enable and output enable. For reads it returns one byte. All DRAM timing windows are parameters, counted in whole controller clock cycles.

After a row has been opened it stays open. A later request to the same row then costs only a column cycle. A request to a different row closes the open row, waits out the precharge time and opens the new row. A free-running interval timer asks for refresh cycles of the CAS-before-RAS kind, where the column strobe falls before the row strobe. A pending refresh takes priority over host traffic: it closes any open row before it runs. After reset the controller waits a power-up delay and runs a burst of refresh cycles before it accepts its first request.

The request side is a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The host must hold the request fields stable while `req_valid` is high and `req_ready` is low. Read data returns as a one-cycle `rsp_valid` pulse that has no back-pressure, so the host must accept it in that cycle.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: The row field is `req_addr[22:10]` and the column field is `req_addr[9:0]`. The row is on `dram_a` when `dram_ras_n` falls. The column, zero-extended, is on `dram_a` when `dram_cas_n` falls for an access.
- R2: While reset is applied, all four strobes are high, `dram_dq_oe` is 0 and `req_ready` is 0. After reset, `req_ready` stays low for at least PWRUP_CYC cycles and until INIT_REF (default 8) refresh cycles have been issued.
- R3: On a write, `dram_we_n` is low and `dram_dq_oe` is high with the data on `dram_dq_o` at least one cycle before `dram_cas_n` falls. `dram_oe_n` stays high throughout the write.
- R4: On a read, `dram_oe_n` is low while CAS is low. `dram_dq_i` is sampled T_CAC cycles after CAS falls and returned on `rsp_data` with a `rsp_valid` pulse that lasts exactly one cycle.
- R5: A request to the row that is already open issues one new CAS cycle and no new RAS fall.
- R6: A request to a row other than the open one raises RAS, opens the new row with a new RAS fall, and accesses the correct byte.
- R7: A refresh cycle drops CAS while RAS is high, then drops RAS, with `dram_we_n` high. After initialization, refresh cycles recur at about REF_INT cycles with no host involvement.
- R8: A refresh that falls due while a row is open closes that row before the refresh runs. The next access to that row therefore opens it again with a new RAS fall.
- R9: Each accepted request produces exactly one column cycle. `req_ready` is low from the cycle after acceptance until that access has finished. It is also low during refresh and whenever CAS is low.
- R10: Every falling edge of RAS, whether for an access or a refresh, follows at least T_RP cycles of RAS high.
- R11: For every access, CAS stays low for at least T_CAC cycles. Between column cycles, CAS stays high for at least T_CP cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Byte address, row in the upper bits |
| req_wdata | input | DW | Write byte |
| rsp_valid | output | 1 | One-cycle pulse carrying read data |
| rsp_data | output | DW | Read byte |
| dram_a | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_o | output | DW | Data driven to the memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_o |
| dram_dq_i | input | DW | Data returned by the memory |

## Verification
The bench includes a behavioural memory model. The model returns a poison byte until CAS has been low for T_CAC cycles, so a controller that samples too early returns wrong data. The model also counts RAS falls. A controller that reopened the row on a page hit, or that left a row open across a refresh, shows the wrong count. Row addresses at the extremes (all ones, all zeros) are used to catch a wrong address split, which would store bytes at aliased locations. A long idle stretch and refreshes that fall due while a row is open test whether refresh is ever starved, and whether the precharge time is skipped when a page is closed for refresh.

// File: rtl/fpm_dram_pkg.sv
package fpm_dram_pkg;
  typedef enum logic [3:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_RCD,
    ST_CSET,
    ST_CAS,
    ST_CPRE,
    ST_OPEN,
    ST_PRECH,
    ST_REF_CAS,
    ST_REF_RAS
  } seq_state_e;
endpackage

// File: rtl/dram_addr_split.sv
module dram_addr_split #(
  parameter int ROW_W = 13,
  parameter int COL_W = 10,
  parameter int MA_W  = 13
) (
  input  logic [ROW_W+COL_W-1:0] addr,
  output logic [ROW_W-1:0]       row,
  output logic [MA_W-1:0]        row_bus,
  output logic [MA_W-1:0]        col_bus
);
  logic [COL_W-1:0] col;

  assign row = addr[ROW_W+COL_W-1:COL_W];
  assign col = addr[COL_W-1:0];

  // pad whichever field is narrower than the shared address bus
  generate
    if (MA_W > ROW_W) begin : g_row_pad
      assign row_bus = {{(MA_W-ROW_W){1'b0}}, row};
    end else begin : g_row_full
      assign row_bus = row;
    end
    if (MA_W > COL_W) begin : g_col_pad
      assign col_bus = {{(MA_W-COL_W){1'b0}}, col};
    end else begin : g_col_full
      assign col_bus = col;
    end
  endgenerate
endmodule

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int INTERVAL = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ack,
  output logic pend
);
  localparam int TW = $clog2(INTERVAL + 1);

  logic [TW-1:0] tcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt <= '0;
      pend <= 1'b0;
    end else begin
      if (ack) pend <= 1'b0;
      if (en) begin
        if (tcnt == TW'(INTERVAL - 1)) begin
          tcnt <= '0;
          pend <= 1'b1;
        end else begin
          tcnt <= tcnt + TW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import fpm_dram_pkg::*;
#(
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int DW        = 8,
  parameter int MA_W      = 13,
  parameter int T_RCD     = 2,
  parameter int T_CAC     = 2,
  parameter int T_CP      = 1,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 5,
  parameter int T_CSR     = 1,
  parameter int PWRUP_CYC = 20000,
  parameter int INIT_REF  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_we,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DW-1:0]          req_wdata,
  output logic                   rsp_valid,
  output logic [DW-1:0]          rsp_data,
  output logic [ROW_W+COL_W-1:0] op_addr,
  input  logic [ROW_W-1:0]       op_row,
  input  logic [MA_W-1:0]        row_bus,
  input  logic [MA_W-1:0]        col_bus,
  input  logic                   ref_pend,
  output logic                   ref_ack,
  output logic                   ref_en,
  output logic [MA_W-1:0]        dram_a,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [DW-1:0]          dram_dq_o,
  output logic                   dram_dq_oe,
  input  logic [DW-1:0]          dram_dq_i
);
  localparam int CNT_W = ($clog2(PWRUP_CYC + 2) > 7) ? $clog2(PWRUP_CYC + 2) : 7;
  localparam int IRW   = $clog2(INIT_REF + 1);

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [IRW-1:0]   init_left;
  logic             have_op;
  logic             op_we;
  logic [DW-1:0]    op_wdata;
  logic [ROW_W-1:0] open_row;
  logic             accept;

  assign ref_en    = (init_left == '0);
  assign req_ready = ((state == ST_IDLE) || (state == ST_OPEN)) && !have_op && ref_en && !ref_pend;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_PWRUP;
      cnt        <= CNT_W'(PWRUP_CYC - 1);
      init_left  <= IRW'(INIT_REF);
      have_op    <= 1'b0;
      op_we      <= 1'b0;
      op_addr    <= '0;
      op_wdata   <= '0;
      open_row   <= '0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      ref_ack    <= 1'b0;
      dram_a     <= '0;
      dram_ras_n <= 1'b1;
      dram_cas_n <= 1'b1;
      dram_we_n  <= 1'b1;
      dram_oe_n  <= 1'b1;
      dram_dq_o  <= '0;
      dram_dq_oe <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      ref_ack   <= 1'b0;
      if (cnt != '0) cnt <= cnt - CNT_W'(1);
      if (accept) begin
        have_op  <= 1'b1;
        op_we    <= req_we;
        op_addr  <= req_addr;
        op_wdata <= req_wdata;
      end
      case (state)
        ST_PWRUP: if (cnt == '0) state <= ST_IDLE;
        ST_IDLE: begin
          if (!ref_en || ref_pend) begin
            dram_cas_n <= 1'b0;
            cnt        <= CNT_W'(T_CSR - 1);
            state      <= ST_REF_CAS;
          end else if (have_op) begin
            dram_ras_n <= 1'b0;
            dram_a     <= row_bus;
            open_row   <= op_row;
            cnt        <= CNT_W'(T_RCD - 1);
            state      <= ST_RCD;
          end
        end
        ST_RCD: if (cnt == '0) begin
          dram_a     <= col_bus;
          dram_we_n  <= ~op_we;
          dram_dq_oe <= op_we;
          dram_dq_o  <= op_wdata;
          state      <= ST_CSET;
        end
        ST_CSET: begin
          dram_cas_n <= 1'b0;
          dram_oe_n  <= op_we;
          cnt        <= CNT_W'(T_CAC - 1);
          state      <= ST_CAS;
        end
        ST_CAS: if (cnt == '0) begin
          dram_cas_n <= 1'b1;
          dram_oe_n  <= 1'b1;
          dram_we_n  <= 1'b1;
          dram_dq_oe <= 1'b0;
          if (!op_we) begin
            rsp_valid <= 1'b1;
            rsp_data  <= dram_dq_i;
          end
          have_op <= 1'b0;
          cnt     <= CNT_W'(T_CP - 1);
          state   <= ST_CPRE;
        end
        ST_CPRE: if (cnt == '0) state <= ST_OPEN;
        ST_OPEN: begin
          if (ref_pend || (have_op && (op_row != open_row))) begin
            dram_ras_n <= 1'b1;
            cnt        <= CNT_W'(T_RP - 1);
            state      <= ST_PRECH;
          end else if (have_op) begin
            dram_a     <= col_bus;
            dram_we_n  <= ~op_we;
            dram_dq_oe <= op_we;
            dram_dq_o  <= op_wdata;
            state      <= ST_CSET;
          end
        end
        ST_PRECH: if (cnt == '0) state <= ST_IDLE;
        ST_REF_CAS: if (cnt == '0) begin
          dram_ras_n <= 1'b0;
          cnt        <= CNT_W'(T_RAS - 1);
          state      <= ST_REF_RAS;
        end
        ST_REF_RAS: if (cnt == '0) begin
          dram_ras_n <= 1'b1;
          dram_cas_n <= 1'b1;
          ref_ack    <= ref_en;
          if (!ref_en) init_left <= init_left - IRW'(1);
          cnt        <= CNT_W'(T_RP - 1);
          state      <= ST_PRECH;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int DW        = 8,
  parameter int T_RCD     = 2,
  parameter int T_CAC     = 2,
  parameter int T_CP      = 1,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 5,
  parameter int T_CSR     = 1,
  parameter int REF_INT   = 1560,
  parameter int PWRUP_CYC = 20000,
  parameter int INIT_REF  = 8,
  localparam int AW       = ROW_W + COL_W,
  localparam int MA_W     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_we,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_data,
  output logic [MA_W-1:0] dram_a,
  output logic            dram_ras_n,
  output logic            dram_cas_n,
  output logic            dram_we_n,
  output logic            dram_oe_n,
  output logic [DW-1:0]   dram_dq_o,
  output logic            dram_dq_oe,
  input  logic [DW-1:0]   dram_dq_i
);
  logic [AW-1:0]    op_addr;
  logic [ROW_W-1:0] op_row;
  logic [MA_W-1:0]  row_bus;
  logic [MA_W-1:0]  col_bus;
  logic             ref_pend;
  logic             ref_ack;
  logic             ref_en;

  dram_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W), .MA_W(MA_W)) u_split (
    .addr    (op_addr),
    .row     (op_row),
    .row_bus (row_bus),
    .col_bus (col_bus)
  );

  dram_ref_timer #(.INTERVAL(REF_INT)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (ref_en),
    .ack   (ref_ack),
    .pend  (ref_pend)
  );

  dram_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DW(DW), .MA_W(MA_W),
    .T_RCD(T_RCD), .T_CAC(T_CAC), .T_CP(T_CP), .T_RP(T_RP),
    .T_RAS(T_RAS), .T_CSR(T_CSR), .PWRUP_CYC(PWRUP_CYC), .INIT_REF(INIT_REF)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_we     (req_we),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .op_addr    (op_addr),
    .op_row     (op_row),
    .row_bus    (row_bus),
    .col_bus    (col_bus),
    .ref_pend   (ref_pend),
    .ref_ack    (ref_ack),
    .ref_en     (ref_en),
    .dram_a     (dram_a),
    .dram_ras_n (dram_ras_n),
    .dram_cas_n (dram_cas_n),
    .dram_we_n  (dram_we_n),
    .dram_oe_n  (dram_oe_n),
    .dram_dq_o  (dram_dq_o),
    .dram_dq_oe (dram_dq_oe),
    .dram_dq_i  (dram_dq_i)
  );
endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
  parameter int T_RP = 3
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_valid,
  input logic dram_ras_n,
  input logic dram_cas_n,
  input logic dram_we_n,
  input logic dram_oe_n,
  input logic dram_dq_oe
);
  logic [7:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) hi_cnt <= '0;
    else if (dram_ras_n) hi_cnt <= (hi_cnt == 8'hFF) ? hi_cnt : hi_cnt + 8'd1;
    else hi_cnt <= '0;
  end

  AST_RST_STROBES_HIGH: assert property (@(posedge clk)
    !rst_n |=> (dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n && !dram_dq_oe && !req_ready))
    else $error("strobes active after reset"); // R2

  AST_WRITE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_ras_n && !dram_we_n) |-> (!$past(dram_we_n) && $past(dram_dq_oe) && dram_oe_n))
    else $error("write strobe or data late"); // R3

  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dram_oe_n && !dram_we_n))
    else $error("output and write enables both active"); // R3

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid)
    else $error("response longer than one cycle"); // R4

  AST_RSP_AFTER_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(!dram_cas_n) && $past(!dram_oe_n)))
    else $error("read data not taken during CAS"); // R4

  AST_CBR_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && dram_ras_n) |-> dram_we_n)
    else $error("write enable low in refresh"); // R7

  AST_NO_READY_IN_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !req_ready)
    else $error("ready while CAS low"); // R9

  AST_RAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (hi_cnt >= 8'(T_RP)))
    else $error("RAS precharge too short"); // R10
endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(.T_RP(T_RP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .dram_ras_n (dram_ras_n),
  .dram_cas_n (dram_cas_n),
  .dram_we_n  (dram_we_n),
  .dram_oe_n  (dram_oe_n),
  .dram_dq_oe (dram_dq_oe)
);

// File: tb/fpm_dram_ctrl_bench.sv
module fpm_dram_ctrl_bench;
  localparam int T_RCD = 2, T_CAC = 2, T_CP = 1, T_RP = 3, T_RAS = 5, T_CSR = 1;
  localparam int REF_INT = 300, PWRUP = 40, INIT_REF = 8;

  // [31] write, [30:8] address, [7:0] write data or expected read data
  localparam logic [31:0] VEC [11] = '{
    32'h801403A1, 32'h801404B2, 32'h001403A1, 32'h001404B2,
    32'hFFFFFFC3, 32'h800000D4, 32'h7FFFFFC3, 32'h000000D4,
    32'h801403E5, 32'h001403E5, 32'h7FFFFFC3
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [22:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_data;
  logic [12:0] dram_a;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [7:0]  dram_dq_o;
  logic [7:0]  dram_dq_i = 8'hEE;

  always #4 clk = ~clk;

  fpm_dram_ctrl #(
    .T_RCD(T_RCD), .T_CAC(T_CAC), .T_CP(T_CP), .T_RP(T_RP), .T_RAS(T_RAS),
    .T_CSR(T_CSR), .REF_INT(REF_INT), .PWRUP_CYC(PWRUP), .INIT_REF(INIT_REF)
  ) u_fpm_dram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .dram_a(dram_a),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_dq_o(dram_dq_o), .dram_dq_oe(dram_dq_oe),
    .dram_dq_i(dram_dq_i)
  );

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // behavioural memory model, sampled away from the active edge
  logic [7:0]  mem [int];
  bit          p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1, p_dqoe = 1'b0, ref_seen = 1'b0;
  int          ras_hi = 0, cas_hi = 0, cas_lo = 0;
  int          act_cnt = 0, ref_cnt = 0, col_cnt = 0, last_ref = 0;
  logic [12:0] row_lat = '0;
  logic [9:0]  col_lat = '0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (p_ras && !dram_ras_n) begin
        check(ras_hi >= T_RP, "R10 RAS precharge", ras_hi, T_RP);
        if (!dram_cas_n) begin
          ref_cnt++;
          if (ref_seen) check(cyc - last_ref <= REF_INT + 40, "R7 refresh gap", cyc - last_ref, REF_INT);
          last_ref = cyc;
          ref_seen = (ref_cnt >= INIT_REF);
        end else begin
          act_cnt++;
          row_lat = dram_a;
        end
      end
      if (p_cas && !dram_cas_n) begin
        if (dram_ras_n) check(dram_we_n, "R7 WE high in refresh", dram_we_n, 1);
        else begin
          check(cas_hi >= T_CP, "R11 CAS precharge", cas_hi, T_CP);
          col_lat = dram_a[9:0];
          col_cnt++;
          if (!dram_we_n) begin
            check(!p_we && p_dqoe && dram_oe_n && dram_dq_oe, "R3 write setup", {p_we, p_dqoe, dram_oe_n}, 3'b011);
            mem[int'({row_lat, col_lat})] = dram_dq_o;
          end
        end
      end
      if (!p_cas && dram_cas_n && !dram_ras_n)
        check(cas_lo >= T_CAC, "R11 CAS width", cas_lo, T_CAC);
      ras_hi = dram_ras_n ? ras_hi + 1 : 0;
      cas_hi = dram_cas_n ? cas_hi + 1 : 0;
      cas_lo = !dram_cas_n ? cas_lo + 1 : 0;
      if (!dram_cas_n && !dram_oe_n && !dram_ras_n && cas_lo >= T_CAC)
        dram_dq_i = mem.exists(int'({row_lat, col_lat})) ? mem[int'({row_lat, col_lat})] : 8'h5A;
      else
        dram_dq_i = 8'hEE;
    end
    p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n; p_dqoe = dram_dq_oe;
  end

  task automatic host_op(input bit we, input logic [22:0] a, input logic [7:0] d, output logic [7:0] rd);
    int t;
    int c0;
    c0 = col_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    t = 0;
    while (!req_ready && t < 2000) begin @(negedge clk); t++; end
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R9 ready low after accept", req_ready, 0);
    rd = 8'h00;
    if (!we) begin
      t = 0;
      while (!rsp_valid && t < 200) begin @(negedge clk); t++; end
      check(rsp_valid, "R4 read response", rsp_valid, 1);
      rd = rsp_data;
      @(negedge clk);
      check(!rsp_valid, "R4 response pulse one cycle", rsp_valid, 0);
    end
    t = 0;
    while (!req_ready && t < 200) begin @(negedge clk); t++; end
    check(col_cnt == c0 + 1, "R9 one column cycle per request", col_cnt - c0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      finish_run();
    end
  end

  initial begin
    logic [7:0] rd;
    int t, a0, r0;
    repeat (3) @(negedge clk);
    check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n && !dram_dq_oe,
          "R2 strobes idle in reset", {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hF);
    check(!req_ready, "R2 not ready in reset", req_ready, 0);
    rst_n = 1'b1;
    t = 0;
    while (!req_ready && t < 5000) begin @(negedge clk); t++; end
    check(ref_cnt == INIT_REF, "R2 init refresh count", ref_cnt, INIT_REF);
    check(t >= PWRUP, "R2 power-up wait", t, PWRUP);

    for (int i = 0; i < 11; i++) begin
      host_op(VEC[i][31], VEC[i][30:8], VEC[i][7:0], rd);
      check(row_lat == VEC[i][30:18], "R1 row field", row_lat, VEC[i][30:18]);
      check(col_lat == VEC[i][17:8], "R1 column field", col_lat, VEC[i][17:8]);
      if (!VEC[i][31]) check(rd == VEC[i][7:0], "R4 read data", rd, VEC[i][7:0]);
    end

    // page hit and page miss right after a refresh, so no refresh intervenes
    r0 = ref_cnt;
    while (ref_cnt == r0) @(negedge clk);
    a0 = act_cnt;
    host_op(1'b1, 23'h002401, 8'h11, rd);
    host_op(1'b1, 23'h002402, 8'h22, rd);
    check(act_cnt == a0 + 1, "R5 page hit keeps row open", act_cnt - a0, 1);
    host_op(1'b0, 23'h002402, 8'h00, rd);
    check(act_cnt == a0 + 1, "R5 page hit read no RAS", act_cnt - a0, 1);
    check(rd == 8'h22, "R5 page hit read data", rd, 8'h22);
    host_op(1'b1, 23'h002801, 8'h33, rd);
    check(act_cnt == a0 + 2, "R6 new row opened", act_cnt - a0, 2);
    host_op(1'b0, 23'h002401, 8'h00, rd);
    check(act_cnt == a0 + 3, "R6 return to earlier row", act_cnt - a0, 3);
    check(rd == 8'h11, "R6 data after row change", rd, 8'h11);

    // refresh falls due while row 9 is open
    r0 = ref_cnt;
    while (ref_cnt == r0) @(negedge clk);
    a0 = act_cnt;
    host_op(1'b0, 23'h002401, 8'h00, rd);
    check(act_cnt == a0 + 1, "R8 row reopened after refresh", act_cnt - a0, 1);
    check(rd == 8'h11, "R8 data after refresh", rd, 8'h11);

    // long idle stretch
    r0 = ref_cnt;
    repeat (REF_INT * 10) @(negedge clk);
    check(ref_cnt - r0 >= 9, "R7 periodic refresh", ref_cnt - r0, 10);
    check(req_ready, "R9 ready when idle", req_ready, 1);

    done = 1'b1;
    finish_run();
  end
endmodule